// File: doc/BRIEF.md
# Streaming Two-List Merge Unit

This block takes two lists of unsigned keys, each already in ascending order and each holding the same count N, and produces one combined ascending list of 2N keys. After a short fill it emits one key per clock cycle. Each list sits in its own memory. The unit reads that memory through a private read port that has one cycle of synchronous latency. The unit drives the address, and the key at that address comes back on the next cycle.

The unit never tests for the end of a list. Each list head is widened by one leading "end" bit. A list that has run out presents a head of all ones across the widened key, so it loses every comparison. The comparison keeps equal keys in order: list A wins a tie. Each emitted key carries a source bit, so a stable merge can be seen from outside.

A run starts when `start` is sampled high while the unit is idle. The length is captured at that moment. `done` pulses once, in the cycle after the last key. Any `start` that arrives while the unit is busy is ignored.

Top module: `merge_stream_unit`

## Requirements
- R1: After reset `busy`, `done` and `out_valid` are low, and no key is emitted until a start is accepted.
- R2: When both lists are ascending, the 2N emitted keys are the union of both lists (duplicates kept) in ascending order.
- R3: On equal keys the element from list A is emitted before the one from list B. `out_src` is 0 for a key taken from A and 1 for a key taken from B.
- R4: Once all N keys of one list have been emitted, that list never wins again. Memory contents at addresses N and above are never emitted, and real keys equal to all ones are still taken in R3 order.
- R5: Count the edge that samples `start` as edge 0. `out_valid` is then high after edges 2 through 2N+1 and low otherwise, one key per cycle with no gaps.
- R6: `done` is high for exactly one cycle, after edge 2N+2 (the cycle after the last key). For N = 0 it is high after edge 1, and no key is emitted.
- R7: `busy` is high from edge 0 until the done cycle and is low in the done cycle.
- R8: `start` and `len` have no effect while `busy` is high. The run continues with the length captured at its start, and no second run follows it.
- R9: The full length N = MAX_N is merged correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a merge when idle |
| len | input | CNT_W | Keys per list (0..MAX_N), captured at start |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the last key |
| a_addr | output | AW | Read address for list A memory |
| a_data | input | KEY_W | Key from list A memory, one cycle after the address |
| b_addr | output | AW | Read address for list B memory |
| b_data | input | KEY_W | Key from list B memory, one cycle after the address |
| out_valid | output | 1 | `out_key` holds a merged key |
| out_key | output | KEY_W | Merged key |
| out_src | output | 1 | 0 = key came from A, 1 = key came from B |

## Verification
The merge is tried with several list shapes, each aimed at a different fault:
- Strictly interleaved lists and lists with an offset stride show whether the comparison picks the smaller head on every cycle.
- Lists where one side is wholly below the other exhaust a list early. They show whether the sentinel takes over, and whether stale memory past N leaks into the output.
- Lists of identical keys, and a case mixing all-ones keys with exhausted lists, separate a correct tie rule from a reversed or unstable one.
- Lengths 0, 1 and MAX_N, plus a start pulse with a different length sent mid-run, pin down the fill latency, the done timing and the length capture.

// File: rtl/merge_stream_pkg.sv
package merge_stream_pkg;

  // Sequencer states for one merge run
  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_FILL = 2'd1,
    MS_RUN  = 2'd2,
    MS_FIN  = 2'd3
  } ms_state_e;

  // Source tag carried with every emitted key
  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } ms_src_e;

endpackage

// File: rtl/merge_stream_reader.sv
// One list lane: read pointer, look-ahead address and sentinel-guarded head.
module merge_stream_reader #(
  parameter  int KEY_W = 64,
  parameter  int MAX_N = 16,
  localparam int AW    = (MAX_N > 1) ? $clog2(MAX_N) : 1,
  localparam int CNT_W = $clog2(MAX_N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [CNT_W-1:0] len_q,
  input  logic [KEY_W-1:0] rd_data,
  output logic [AW-1:0]    rd_addr,
  output logic [CNT_W-1:0] ptr,
  output logic [KEY_W:0]   head
);

  logic [CNT_W-1:0] ptr_q;
  logic [CNT_W-1:0] ptr_nxt;
  logic             lane_empty;

  // The extra top bit marks the end of the list, so a spent lane loses
  // every comparison, even against a real all-ones key.
  function automatic logic [KEY_W:0] guard_head(input logic spent,
                                                input logic [KEY_W-1:0] d);
    return spent ? {(KEY_W + 1){1'b1}} : {1'b0, d};
  endfunction

  // The pointer that will hold after this edge is presented as the address,
  // so the synchronous read returns the new head exactly one cycle later.
  assign ptr_nxt    = clear ? '0 : ptr_q + CNT_W'(advance);
  assign rd_addr    = ptr_nxt[AW-1:0];
  assign lane_empty = (ptr_q >= len_q);
  assign head       = guard_head(lane_empty, rd_data);
  assign ptr        = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_nxt;
  end

endmodule

// File: rtl/merge_stream_pick.sv
// Head comparison: B wins only when A's head is strictly larger.
module merge_stream_pick #(
  parameter int KEY_W = 64
) (
  input  logic [KEY_W:0]   head_a,
  input  logic [KEY_W:0]   head_b,
  output logic             take_b,
  output logic [KEY_W-1:0] key
);

  function automatic logic b_first(input logic [KEY_W:0] ha,
                                   input logic [KEY_W:0] hb);
    return ha > hb;
  endfunction

  assign take_b = b_first(head_a, head_b);
  assign key    = take_b ? head_b[KEY_W-1:0] : head_a[KEY_W-1:0];

endmodule

// File: rtl/merge_stream_ctrl.sv
// Run sequencer: accept, one fill cycle, 2N emit cycles, finish, done pulse.
module merge_stream_ctrl
  import merge_stream_pkg::*;
#(
  parameter  int MAX_N = 16,
  localparam int CNT_W = $clog2(MAX_N + 1),
  localparam int BW    = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             load,
  output logic             running,
  output logic             last_beat,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] len_q
);

  ms_state_e        state_q;
  logic [BW-1:0]    beat_q;
  logic [BW-1:0]    total_beats;
  logic             done_q;

  function automatic logic [BW-1:0] beats_of(input logic [CNT_W-1:0] n);
    return {n, 1'b0};
  endfunction

  assign total_beats = beats_of(len_q);
  assign load        = (state_q == MS_IDLE) && start;
  assign running     = (state_q == MS_RUN);
  assign last_beat   = running && (beat_q == total_beats - BW'(1));
  assign busy        = (state_q != MS_IDLE);
  assign done        = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
      beat_q  <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == MS_FIN);
      unique case (state_q)
        MS_IDLE: begin
          if (start) begin
            len_q   <= len;
            beat_q  <= '0;
            state_q <= (len == '0) ? MS_FIN : MS_FILL;
          end
        end
        MS_FILL: state_q <= MS_RUN;
        MS_RUN: begin
          beat_q <= beat_q + BW'(1);
          if (last_beat) state_q <= MS_FIN;
        end
        MS_FIN:  state_q <= MS_IDLE;
        default: state_q <= MS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/merge_stream_unit.sv
module merge_stream_unit
  import merge_stream_pkg::*;
#(
  parameter  int KEY_W = 64,
  parameter  int MAX_N = 16,
  localparam int AW    = (MAX_N > 1) ? $clog2(MAX_N) : 1,
  localparam int CNT_W = $clog2(MAX_N + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic             done,
  output logic [AW-1:0]    a_addr,
  input  logic [KEY_W-1:0] a_data,
  output logic [AW-1:0]    b_addr,
  input  logic [KEY_W-1:0] b_data,
  output logic             out_valid,
  output logic [KEY_W-1:0] out_key,
  output logic             out_src
);

  localparam int LANES = 2;

  // Named internal events, also observed by the bound checker
  logic             accept_start;
  logic             running;
  logic             last_beat;
  logic             take_a;
  logic             take_b;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] ptr_a;
  logic [CNT_W-1:0] ptr_b;
  logic [KEY_W-1:0] pick_key;

  logic [AW-1:0]    lane_addr [LANES];
  logic [KEY_W-1:0] lane_data [LANES];
  logic [KEY_W:0]   lane_head [LANES];
  logic [CNT_W-1:0] lane_ptr  [LANES];
  logic             lane_adv  [LANES];

  logic             valid_q;
  logic [KEY_W-1:0] key_q;
  logic             src_q;

  merge_stream_ctrl #(.MAX_N(MAX_N)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .len       (len),
    .load      (accept_start),
    .running   (running),
    .last_beat (last_beat),
    .busy      (busy),
    .done      (done),
    .len_q     (len_q)
  );

  assign lane_data[0] = a_data;
  assign lane_data[1] = b_data;
  assign lane_adv[0]  = take_a;
  assign lane_adv[1]  = running && take_b;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    merge_stream_reader #(.KEY_W(KEY_W), .MAX_N(MAX_N)) u_reader (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept_start),
      .advance (lane_adv[g]),
      .len_q   (len_q),
      .rd_data (lane_data[g]),
      .rd_addr (lane_addr[g]),
      .ptr     (lane_ptr[g]),
      .head    (lane_head[g])
    );
  end

  merge_stream_pick #(.KEY_W(KEY_W)) u_pick (
    .head_a (lane_head[0]),
    .head_b (lane_head[1]),
    .take_b (take_b),
    .key    (pick_key)
  );

  assign take_a = running && !take_b;
  assign a_addr = lane_addr[0];
  assign b_addr = lane_addr[1];
  assign ptr_a  = lane_ptr[0];
  assign ptr_b  = lane_ptr[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      key_q   <= '0;
      src_q   <= SRC_A;
    end else begin
      valid_q <= running;
      if (running) begin
        key_q <= pick_key;
        src_q <= take_b ? SRC_B : SRC_A;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_key   = key_q;
  assign out_src   = src_q;

endmodule

// File: rtl/merge_stream_unit_chk.sv
module merge_stream_unit_chk #(
  parameter  int KEY_W = 64,
  parameter  int MAX_N = 16,
  localparam int CNT_W = $clog2(MAX_N + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             out_valid,
  input logic [KEY_W-1:0] out_key,
  input logic             out_src,
  input logic             running,
  input logic             last_beat,
  input logic [CNT_W-1:0] len_q,
  input logic [CNT_W-1:0] ptr_a,
  input logic [CNT_W-1:0] ptr_b
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid);

  assert_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> (out_key >= $past(out_key)));

  assert_tie_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid) && $past(out_src) &&
     (out_key == $past(out_key))) |-> out_src);

  assert_ptr_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_a <= len_q) && (ptr_b <= len_q));

  assert_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> out_valid);

  assert_last_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> !running);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !out_valid));

  assert_len_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(len_q));

endmodule

bind merge_stream_unit merge_stream_unit_chk #(.KEY_W(KEY_W), .MAX_N(MAX_N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .out_valid (out_valid),
  .out_key   (out_key),
  .out_src   (out_src),
  .running   (running),
  .last_beat (last_beat),
  .len_q     (len_q),
  .ptr_a     (ptr_a),
  .ptr_b     (ptr_b)
);

// File: tb/merge_stream_unit_test.sv
`timescale 1ns/1ps
module merge_stream_unit_test;

  localparam int KEY_W = 64;
  localparam int MAX_N = 16;
  localparam int AW    = 4;
  localparam int CNT_W = 5;
  localparam int NV    = 6;

  typedef struct packed {
    int n;
    int a_base;
    int a_step;
    int b_base;
    int b_step;
    int exp_first;
    int exp_last;
    int kind;     // 0 plain, 1 early exhaustion, 2 full length, 3 ties
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8,   0, 2,   1, 2, 0,  15, 0},
    '{16,  0, 1, 100, 1, 0, 115, 1},
    '{16, 200, 3,  0, 1, 0, 245, 2},
    '{5,  10, 0,  10, 0, 10, 10, 3},
    '{1,   7, 0,   3, 0, 3,   7, 0},
    '{12,  5, 4,   6, 4, 5,  50, 0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] len = '0;
  logic             busy, done, out_valid, out_src;
  logic [AW-1:0]    a_addr, b_addr;
  logic [KEY_W-1:0] a_data, b_data, out_key;

  logic [KEY_W-1:0] mem_a [MAX_N];
  logic [KEY_W-1:0] mem_b [MAX_N];

  int compared = 0;
  int mismatched = 0;

  logic [KEY_W-1:0] got_key [2*MAX_N];
  logic             got_src [2*MAX_N];
  logic [KEY_W-1:0] ref_key [2*MAX_N];
  logic             ref_src [2*MAX_N];

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    a_data <= mem_a[a_addr];
    b_data <= mem_b[b_addr];
  end

  merge_stream_unit #(.KEY_W(KEY_W), .MAX_N(MAX_N)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len),
    .busy(busy), .done(done),
    .a_addr(a_addr), .a_data(a_data), .b_addr(b_addr), .b_data(b_data),
    .out_valid(out_valid), .out_key(out_key), .out_src(out_src)
  );

  task automatic chk(input bit ok, input string what,
                     input logic [63:0] act, input logic [63:0] exp_v);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp_v);
    end
  endtask

  function automatic string kind_tag(input int k);
    case (k)
      1:       return "R4";
      2:       return "R9";
      3:       return "R3";
      default: return "R2";
    endcase
  endfunction

  // Stable reference: concatenate A then B, insertion sort on key only.
  task automatic build_ref(input int n);
    for (int i = 0; i < n; i++) begin
      ref_key[i] = mem_a[i];     ref_src[i] = 1'b0;
      ref_key[n+i] = mem_b[i];   ref_src[n+i] = 1'b1;
    end
    for (int i = 1; i < 2*n; i++) begin
      for (int j = i; j > 0; j--) begin
        if (ref_key[j-1] > ref_key[j]) begin
          logic [KEY_W-1:0] tk; logic ts;
          tk = ref_key[j]; ref_key[j] = ref_key[j-1]; ref_key[j-1] = tk;
          ts = ref_src[j]; ref_src[j] = ref_src[j-1]; ref_src[j-1] = ts;
        end else break;
      end
    end
  endtask

  task automatic fill_lists(input int n, input int ab, input int as_, input int bb, input int bs);
    for (int i = 0; i < MAX_N; i++) begin
      mem_a[i] = (i < n) ? 64'(ab + i*as_) : 64'd0;
      mem_b[i] = (i < n) ? 64'(bb + i*bs) : 64'd0;
    end
  endtask

  task automatic do_run(input int n, input int poke_e, input int poke_len, input string tag);
    int e, nv, first_e, last_e, done_e, exp_done;
    bit busy_ok, busy_at_done, done_next;
    nv = 0; first_e = -1; last_e = -1; done_e = -1; busy_ok = 1; busy_at_done = 0;
    build_ref(n);
    @(negedge clk); start = 1'b1; len = CNT_W'(n);
    e = -1;
    while (done_e < 0 && e < 200) begin
      @(posedge clk); e++;
      @(negedge clk);
      start = (e == poke_e);
      if (e == poke_e) len = CNT_W'(poke_len);
      if (out_valid) begin
        if (nv < 2*MAX_N) begin got_key[nv] = out_key; got_src[nv] = out_src; end
        if (nv == 0) first_e = e;
        last_e = e;
        nv++;
      end
      if (done) begin done_e = e; busy_at_done = busy; end
      else if (!busy) busy_ok = 0;
    end
    @(negedge clk); done_next = done; start = 1'b0;
    exp_done = (n == 0) ? 1 : 2*n + 2;
    chk(nv == 2*n, {"R5 key count ", tag}, 64'(nv), 64'(2*n));
    if (n > 0) begin
      chk(first_e == 2, {"R5 first key edge ", tag}, 64'(first_e), 64'd2);
      chk(last_e == 2*n + 1, {"R5 last key edge ", tag}, 64'(last_e), 64'(2*n + 1));
    end
    chk(done_e == exp_done, {"R6 done edge ", tag}, 64'(done_e), 64'(exp_done));
    chk(!done_next, {"R6 done one cycle ", tag}, 64'(done_next), 64'd0);
    chk(busy_ok, {"R7 busy held during run ", tag}, 64'(busy_ok), 64'd1);
    chk(!busy_at_done, {"R7 busy low at done ", tag}, 64'(busy_at_done), 64'd0);
    for (int i = 0; i < 2*n && i < nv; i++) begin
      chk(got_key[i] == ref_key[i], $sformatf("R2 key %0d %s", i, tag), got_key[i], ref_key[i]);
      chk(got_src[i] == ref_src[i], $sformatf("R3 source %0d %s", i, tag), 64'(got_src[i]), 64'(ref_src[i]));
    end
  endtask

  initial begin : watchdog
    #(5.0 * 100000);
    mismatched++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < MAX_N; i++) begin mem_a[i] = '0; mem_b[i] = '0; end
    // R1: reset, with start held high during reset
    start = 1'b1; len = 5'd4;
    repeat (3) @(posedge clk);
    @(negedge clk); start = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R1 busy after reset", 64'(busy), 64'd0);
    chk(!done, "R1 done after reset", 64'(done), 64'd0);
    chk(!out_valid, "R1 out_valid after reset", 64'(out_valid), 64'd0);
    repeat (4) @(negedge clk);
    chk(!out_valid && !busy, "R1 quiet without start", 64'(out_valid), 64'd0);

    // Table-driven cases
    for (int v = 0; v < NV; v++) begin
      fill_lists(VECS[v].n, VECS[v].a_base, VECS[v].a_step, VECS[v].b_base, VECS[v].b_step);
      do_run(VECS[v].n, -1, 0, kind_tag(VECS[v].kind));
      chk(got_key[0] == 64'(VECS[v].exp_first), "R2 table first key", got_key[0], 64'(VECS[v].exp_first));
      chk(got_key[2*VECS[v].n-1] == 64'(VECS[v].exp_last), "R2 table last key",
          got_key[2*VECS[v].n-1], 64'(VECS[v].exp_last));
    end

    // R2: interleaved reference example, expect 0..15
    begin
      int la [8] = '{0, 1, 2, 4, 7, 11, 12, 14};
      int lb [8] = '{3, 5, 6, 8, 9, 10, 13, 15};
      fill_lists(0, 0, 0, 0, 0);
      for (int i = 0; i < 8; i++) begin mem_a[i] = 64'(la[i]); mem_b[i] = 64'(lb[i]); end
      do_run(8, -1, 0, "R2");
      for (int i = 0; i < 16; i++)
        chk(got_key[i] == 64'(i), "R2 example sequence", got_key[i], 64'(i));
    end

    // R4: all-ones keys against exhausted lanes
    fill_lists(0, 0, 0, 0, 0);
    mem_a[0] = 64'd0; mem_a[1] = '1; mem_a[2] = '1;
    mem_b[0] = '1;    mem_b[1] = '1; mem_b[2] = '1;
    do_run(3, -1, 0, "R4");
    chk(got_src[2] == 1'b0 && got_src[3] == 1'b1, "R4 all-ones split A/B",
        64'({got_src[2], got_src[3]}), 64'b01);

    // R6: zero length
    do_run(0, -1, 0, "R6");

    // R8: start with a new length mid-run is ignored
    fill_lists(4, 1, 3, 2, 3);
    do_run(4, 3, 9, "R8");
    repeat (4) begin
      @(negedge clk);
      chk(!out_valid && !busy, "R8 no second run after ignored start",
          64'({busy, out_valid}), 64'd0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule